// File: doc/BRIEF.md
# Real-Time Periodic Interrupt Generator

This block produces a periodic tick from the bus clock. Each time a programmable interval has elapsed, it sets a real-time flag, and it raises a level interrupt request while that flag and its enable bit are both 1. A 2-bit rate field chooses the interval. The interval is always a power-of-two multiple of a base period of 8192 bus cycles.

Three byte-wide registers hold the state, and a simple single-cycle write port with a combinational read port reaches them. The rate field sits in a control register. The enable bit sits in a mask register. The flag sits in a flag register, and software clears it by writing a 1 to its bit. Any write to the control register restarts the interval from zero. The bits of the control and mask registers that belong to neighbouring functions are kept as plain storage.

Top module: `rti_gen`

## Requirements
- R1: Synchronous active-low reset clears the control, mask and flag registers, drops `irq` and restarts the interval count from zero.
- R2: The rate field is control register (address 0) bits [1:0], value n. The interval is 8192 × 2^n bus cycles. The flag (flag register at address 2, bit 6) becomes 1 on the clock edge that ends the interval, which is edge 8192 × 2^n counted from the restart edge.
- R3: When an interval ends, the count restarts at once, so with no other writes the flag is set again one full interval later.
- R4: A write to the control register restarts the count from zero and never sets the flag, even when it falls on the edge that would have ended the interval.
- R5: Writing the flag register with bit 6 = 1 clears the flag. Writing it with bit 6 = 0 leaves the flag unchanged.
- R6: `irq` is 1 exactly while the flag is 1 and the enable bit (mask register at address 1, bit 6) is 1.
- R7: If an interval ends on the same edge as a write that clears the flag, the flag ends up 1.
- R8: The control and mask registers read back every bit that was written. The flag register reads 0 in every bit except bit 6.
- R9: Address 3 selects no register. A write to it changes nothing, and a read of it returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 mask, 2 flag |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 8 | Combinational read data |
| irq | output | 1 | Level interrupt request |

## Verification
The interval is timed at all four rate codes. The flag is sampled one cycle before and exactly on the expected edge, which separates a correct period from a divider that is off by one or that uses the wrong rate. One control write lands in the middle of an interval and a second lands exactly on the terminal edge. These show that the count restarts from the write and that the write never sets the flag. A clear that lands on a terminal edge shows whether set or clear takes priority. Register patterns with alternating bits show whether the plain-storage bits are kept and whether the flag register hides everything but its flag.

// File: rtl/rti_pkg.sv
// Package rti_pkg
// Shared register map and bit positions for the real-time periodic
// interrupt generator. Assumes a byte-wide register interface.
package rti_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int RATE_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_MASK = 2'd1,
        SEL_FLAG = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Bit 6 holds both the enable bit in the mask register and the
    // flag bit in the flag register.
    localparam int EN_BIT   = 6;
    localparam int FLAG_BIT = 6;
endpackage

// File: rtl/rti_regs.sv
// Module rti_regs
// Holds the control and mask registers. Every bit is stored, and only
// the rate field and the enable bit are used here. A write to the
// control register produces a one-cycle restart pulse for the divider.
// Assumes that writes complete in one cycle.
module rti_regs
    import rti_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] mask_q,
    output logic              restart
);
    logic wr_ctrl;
    logic wr_mask;

    // Decode the write strobes from the address.
    always_comb begin
        wr_ctrl = wr_en && (reg_sel_e'(wr_addr) == SEL_CTRL);
        wr_mask = wr_en && (reg_sel_e'(wr_addr) == SEL_MASK);
        restart = wr_ctrl;
    end

    // Control register: the rate field plus neighbour storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= wr_data;
    end

    // Mask register: the enable bit plus neighbour storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_mask)
            mask_q <= wr_data;
    end
endmodule

// File: rtl/rti_divider.sv
// Module rti_divider
// A reloading counter whose terminal count comes from the rate field:
// BASE_PERIOD * 2^rate - 1. The tick output is high during the last
// cycle of each interval. A restart pulse clears the count and hides
// the tick. Assumes a rate change arrives together with a restart.
module rti_divider #(
    parameter int BASE_PERIOD = 8192,
    parameter int RATE_W      = 2,
    localparam int NUM_RATES  = 1 << RATE_W,
    localparam int CNT_W      = $clog2(BASE_PERIOD << (NUM_RATES - 1))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [RATE_W-1:0] rate,
    output logic              tick,
    output logic [CNT_W-1:0]  cnt
);
    logic [CNT_W-1:0] term_tbl [NUM_RATES];

    // One terminal count for each rate code.
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_term
        localparam int TERM = (BASE_PERIOD << g) - 1;
        assign term_tbl[g] = CNT_W'(TERM);
    end

    // End of interval, suppressed when a restart takes this cycle.
    always_comb begin
        tick = (cnt == term_tbl[rate]) && !restart;
    end

    // Count up, and reload on reset, restart or the end of an interval.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/rti_flag.sv
// Module rti_flag
// The real-time flag and the interrupt request. The tick sets the flag.
// A clear request (a 1 written to the flag bit) clears it, and the set
// takes priority over the clear. Assumes the tick is already suppressed
// on restart cycles.
module rti_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr_req,
    input  logic enable,
    output logic flag_q,
    output logic irq
);
    // Update the flag, with set taking priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (tick)
            flag_q <= 1'b1;
        else if (clr_req)
            flag_q <= 1'b0;
    end

    // Level request while the flag is set and enabled.
    always_comb begin
        irq = flag_q && enable;
    end
endmodule

// File: rtl/rti_gen.sv
// Module rti_gen
// Top level of the real-time periodic interrupt generator. It connects
// the registers, the divider and the flag, and it muxes the read data.
// Assumes a synchronous active-low reset and a combinational read port.
module rti_gen #(
    parameter int BASE_PERIOD = 8192
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [rti_pkg::ADDR_W-1:0] wr_addr,
    input  logic [rti_pkg::DATA_W-1:0] wr_data,
    input  logic [rti_pkg::ADDR_W-1:0] rd_addr,
    output logic [rti_pkg::DATA_W-1:0] rd_data,
    output logic                       irq
);
    import rti_pkg::*;

    localparam int NUM_RATES = 1 << RATE_W;
    localparam int CNT_W     = $clog2(BASE_PERIOD << (NUM_RATES - 1));

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] mask_q;
    logic              restart;
    logic              tick;
    logic [CNT_W-1:0]  div_cnt;
    logic              flag_q;
    logic              clr_req;
    logic              irq_en;

    rti_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .mask_q  (mask_q),
        .restart (restart)
    );

    rti_divider #(
        .BASE_PERIOD (BASE_PERIOD),
        .RATE_W      (RATE_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .rate    (ctrl_q[RATE_W-1:0]),
        .tick    (tick),
        .cnt     (div_cnt)
    );

    // Decode the clear request and the enable bit.
    always_comb begin
        clr_req = wr_en && (reg_sel_e'(wr_addr) == SEL_FLAG) && wr_data[FLAG_BIT];
        irq_en  = mask_q[EN_BIT];
    end

    rti_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .clr_req (clr_req),
        .enable  (irq_en),
        .flag_q  (flag_q),
        .irq     (irq)
    );

    // Read mux: the flag register shows only its flag bit.
    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(rd_addr))
            SEL_CTRL: rd_data = ctrl_q;
            SEL_MASK: rd_data = mask_q;
            SEL_FLAG: rd_data[FLAG_BIT] = flag_q;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rti_gen_chk.sv
// Module rti_gen_chk
// Checker bound to rti_gen. It relates the write port, the divider and
// the flag over time. Assumes that reset is low at the first clock edge.
module rti_gen_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [7:0]       wr_data,
    input logic             irq,
    input logic             flag_q,
    input logic             tick,
    input logic [CNT_W-1:0] div_cnt
);
    logic wr_ctrl_p;
    logic clr_p;

    // Write decodes taken from the ports.
    always_comb begin
        wr_ctrl_p = wr_en && (wr_addr == 2'd0);
        clr_p     = wr_en && (wr_addr == 2'd2) && wr_data[6];
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!flag_q && !irq && div_cnt == '0)); // R1

    AST_FLAG_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(tick)); // R2

    AST_TICK_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (div_cnt == '0 && flag_q)); // R3

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl_p |=> div_cnt == '0); // R4

    AST_RESTART_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl_p && !flag_q) |=> !flag_q); // R4

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_p && !tick) |=> !flag_q); // R5

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_q); // R6

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && clr_p) |=> flag_q); // R7
endmodule

bind rti_gen rti_gen_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .irq     (irq),
    .flag_q  (flag_q),
    .tick    (tick),
    .div_cnt (div_cnt)
);

// File: tb/rti_gen_bench.sv
`timescale 1ns/1ps
module rti_gen_bench;
    localparam int BASE = 8192;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rti_gen u_rti_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq     (irq)
    );

    // Vector: {req[3:0], addr[1:0], wdata[7:0], expected readback[7:0]}
    localparam int NV = 7;
    localparam logic [21:0] VEC [NV] = '{
        {4'd8, 2'd0, 8'hFC, 8'hFC},
        {4'd8, 2'd1, 8'hBF, 8'hBF},
        {4'd8, 2'd1, 8'h55, 8'h55},
        {4'd8, 2'd2, 8'hBF, 8'h00},
        {4'd9, 2'd3, 8'hAA, 8'h00},
        {4'd8, 2'd0, 8'h03, 8'h03},
        {4'd8, 2'd0, 8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic check_flag(input string req, input logic exp);
        logic [7:0] v;
        rd(2'd2, v);
        check(req, {7'd0, v[6]}, {7'd0, exp});
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (198000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        @(negedge clk);
        do_reset;
        // R1: the reset state.
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 reset read", v, 8'h00);
        end
        check("R1 irq", {7'd0, irq}, 8'h00);

        // Table walk of register storage: R8, R9.
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][17:16], VEC[i][15:8]);
            rd(VEC[i][17:16], v);
            check($sformatf("R%0d table %0d", VEC[i][21:18], i), v, VEC[i][7:0]);
        end
        // R9: the address 3 write left the other registers intact.
        rd(2'd1, v);
        check("R9 mask intact", v, 8'h55);

        do_reset;
        // R2 rate 0: restart with a control write, then time the flag.
        wr(2'd0, 8'h00);
        wait_n(BASE - 1);
        check_flag("R2 rate0 before", 1'b0);
        wait_n(1);
        check_flag("R2 rate0 edge", 1'b1);
        check("R6 irq disabled", {7'd0, irq}, 8'h00);
        wr(2'd1, 8'h40);                       // edge P+1
        check("R6 irq enabled", {7'd0, irq}, 8'h01);
        wr(2'd2, 8'hBF);                       // edge P+2, bit 6 = 0
        check_flag("R5 write zero keeps", 1'b1);
        wr(2'd2, 8'h40);                       // edge P+3
        check_flag("R5 write one clears", 1'b0);
        check("R6 irq drops", {7'd0, irq}, 8'h00);
        wait_n(BASE - 4);
        check_flag("R3 second before", 1'b0);
        wait_n(1);
        check_flag("R3 second edge", 1'b1);

        // R4: a mid-interval restart at rate 1.
        wr(2'd2, 8'h40);
        wait_n(100);
        wr(2'd0, 8'h01);
        wait_n(2 * BASE - 1);
        check_flag("R4 restart before", 1'b0);
        wait_n(1);
        check_flag("R2 rate1 edge", 1'b1);

        // R4: a control write on the terminal edge does not set the flag.
        wr(2'd2, 8'h40);
        wr(2'd0, 8'h00);
        wait_n(BASE - 1);
        wr(2'd0, 8'h00);
        check_flag("R4 coincident write", 1'b0);
        // R7: a clear on the terminal edge loses to the set.
        wait_n(BASE - 1);
        wr(2'd2, 8'h40);
        check_flag("R7 set wins", 1'b1);
        check("R6 irq with both", {7'd0, irq}, 8'h01);

        // R2 rate 2.
        wr(2'd2, 8'h40);
        wr(2'd0, 8'h02);
        wait_n(4 * BASE - 1);
        check_flag("R2 rate2 before", 1'b0);
        wait_n(1);
        check_flag("R2 rate2 edge", 1'b1);

        // R2 rate 3.
        wr(2'd2, 8'h40);
        wr(2'd0, 8'h03);
        wait_n(8 * BASE - 1);
        check_flag("R2 rate3 before", 1'b0);
        wait_n(1);
        check_flag("R2 rate3 edge", 1'b1);

        // R1: reset during operation clears everything and restarts.
        do_reset;
        for (int a = 0; a < 3; a++) begin
            rd(2'(a), v);
            check("R1 mid-run reset", v, 8'h00);
        end
        check("R1 irq after reset", {7'd0, irq}, 8'h00);
        wait_n(BASE - 1);
        check_flag("R1 count restarted before", 1'b0);
        wait_n(1);
        check_flag("R1 count restarted edge", 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule